// File: doc/BRIEF.md
# Programmable Block-Move DMA Channel

This block is one DMA channel that copies a block of bytes from a source region to a destination region without processor help. Software loads a source address, a destination address, a byte count and a control word. Writing the control word with its start bit set arms the channel. The channel then asks for the system bus, waits for grant, and runs bus cycles until the count reaches zero. It can run in two modes. In the two-cycle mode each cycle pair reads from the source and writes to the destination. In the flyby mode one bus cycle carries one transfer, and an external peripheral supplies or takes the data through the acknowledge handshake.

The source and destination port sizes are chosen separately. When they differ, an internal 32-bit holding register packs or unpacks the data. Transfers are grouped into elements the size of the wider port. Transfers can be triggered by an external request, either as a level (burst) or as one element per rising edge (cycle steal). They can also be triggered internally, and internal triggers can be limited to a share of bus bandwidth. At every element boundary the channel gives the bus back if a high-priority interrupt is pending.

Top module: `dma_chan`

## Requirements
- R1: After reset, `busy`, `done_flag`, `err_flag`, `irq`, `bus_req` and `bus_valid` are all low.
- R2: Register writes use `cfg_sel` 0 for the source address, 1 for the destination address, 2 for the byte count and 3 for control. The control bits are: bit0 start, bit1 flyby, bit2 flyby address is the destination, bit3 source increment, bit4 destination increment, bits[6:5] source size, bits[8:7] destination size, bit9 burst, bit10 internal trigger, bits[12:11] bandwidth, bit13 interrupt enable. Register writes made while `busy` is high have no effect.
- R3: In two-cycle mode, the bytes at the destination equal the source bytes in the same order. Each address advances by its own port size after each of its cycles when its increment bit is set, and stays fixed when that bit is clear.
- R4: Size codes are 0 = byte, 1 = word (2 bytes) and 2 = long (4 bytes). An element is as wide as the wider port. It takes element/source-size reads, followed by element/destination-size writes. Data is packed in ascending byte order.
- R5: In flyby mode there is one bus cycle per transfer, of the source size. The address comes from the destination register when bit2 is set and from the source register otherwise. `bus_we` equals bit2, and `ext_ack` is high during each cycle.
- R6: Starting flyby mode with the internal trigger sets `err_flag` and runs no bus cycle.
- R7: `ext_last` is high during the final bus cycle, which is the one that brings the count to zero. After it, `done_flag` is set and `busy` drops. Starting with a count of zero sets `done_flag` without any bus cycle. `irq` equals the interrupt enable ANDed with (done or error).
- R8: In burst mode, elements follow each other while `ext_req` is high. In cycle-steal mode, each rising edge of `ext_req` allows exactly one element.
- R9: With the internal trigger and bandwidth code b, the channel releases the bus after every b+1 elements and stays off the bus for 3-b cycles. With b = 3 it keeps the bus for the whole block.
- R10: While `hi_irq` is high, the channel starts no new element. If `hi_irq` is high at an element boundary, `bus_req` is low in the next cycle. The channel resumes once `hi_irq` falls.
- R11: A `bus_err` on a cycle stops the channel, sets `err_flag` and leaves `done_flag` clear.
- R12: `bus_valid` never rises unless `bus_gnt` was high in the cycle before. While grant is withheld, `bus_req` stays high and no cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Channel armed or transferring |
| done_flag | output | 1 | Block completed |
| err_flag | output | 1 | Configuration or bus error |
| irq | output | 1 | Interrupt request |
| ext_req | input | 1 | External transfer request |
| ext_ack | output | 1 | External acknowledge during owned cycles |
| ext_last | output | 1 | Final transfer marker |
| hi_irq | input | 1 | High-priority interrupt pending |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | Cycle is a write |
| bus_addr | output | 32 | Cycle address |
| bus_size | output | 2 | Cycle size code |
| bus_wdata | output | 32 | Write data, low lanes |
| bus_rdata | input | 32 | Read data, low lanes |
| bus_ack | input | 1 | Cycle completes |
| bus_err | input | 1 | Cycle fails |

## Verification
The bench targets mixed port sizes in both directions. A design with the wrong pack shift or read/write ratio would scramble the destination bytes or run the wrong number of cycles. It also targets cycle-steal pacing, where a level-sensitive design would move the whole block on the first pulse, and the bandwidth windows, where a missing or miscounted release shows up as the wrong number of bus request rises. The remaining probes cover these cases:
- A flyby start with the internal trigger, and a zero count: a careless design would issue bus cycles for either.
- A withheld grant, where a write to the source register during the wait must not redirect the copy.
- A pending interrupt that must keep the channel off the bus.

// File: rtl/dma_pkg.sv
// Shared types and helpers for the DMA channel.
// Assumes size codes 0/1/2 mean 1/2/4 bytes; code 3 is treated as 4 bytes.
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_REQ, ST_RD, ST_WR, ST_FLY
    } dma_state_t;

    localparam int SEL_SRC   = 0;
    localparam int SEL_DST   = 1;
    localparam int SEL_COUNT = 2;
    localparam int SEL_CTRL  = 3;

    localparam int CB_START = 0;
    localparam int CB_FLY   = 1;
    localparam int CB_DIRD  = 2;
    localparam int CB_SINC  = 3;
    localparam int CB_DINC  = 4;
    localparam int CB_SSZ   = 5;
    localparam int CB_DSZ   = 7;
    localparam int CB_BURST = 9;
    localparam int CB_INTR  = 10;
    localparam int CB_BW    = 11;
    localparam int CB_IEN   = 13;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_log(input logic [1:0] sz);
        return (sz == 2'd3) ? 2'd2 : sz;
    endfunction
endpackage

// File: rtl/dma_addr_gen.sv
// Address register for one side of the channel.
// Loads from software; advances by the step size when stepping is enabled.
module dma_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          inc_en,
    input  logic [2:0]    step_bytes,
    output logic [AW-1:0] addr
);
    // Hold, load or advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n)              addr <= '0;
        else if (load)           addr <= load_val;
        else if (step && inc_en) addr <= addr + AW'(step_bytes);
    end
endmodule

// File: rtl/dma_pace.sv
// Bandwidth pacer for internally triggered transfers.
// Counts elements in a 4-slot window; after bw+1 elements it holds the bus
// off for 3-bw cycles. bw==3 never holds. Assumes bw is stable while active.
module dma_pace (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] bw,
    input  logic       elem_done,
    output logic       gap_next,
    output logic       hold
);
    logic [1:0] used;
    logic [1:0] gap;

    assign gap_next = (bw != 2'd3) && (used == bw);
    assign hold     = (gap != 2'd0);

    // Track window usage and run the idle gap down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            used <= '0;
            gap  <= '0;
        end else begin
            if (gap != 2'd0) gap <= gap - 2'd1;
            if (elem_done) begin
                if (gap_next) begin
                    used <= '0;
                    gap  <= 2'd3 - bw;
                end else begin
                    used <= used + 2'd1;
                end
            end
        end
    end

    p_gap_starts_r9: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (elem_done && gap_next) |=> hold);
    p_full_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bw == 2'd3 && !clear && !$past(clear)) |-> !hold);
endmodule

// File: rtl/dma_chan.sv
// Single DMA channel: two-cycle or flyby transfers, separate port sizes with
// packing through a holding register, burst / cycle-steal / internal triggers,
// bandwidth pacing and interrupt yield. Data sits on the low byte lanes.
// Assumes the byte count is a multiple of the element size.
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic          busy,
    output logic          done_flag,
    output logic          err_flag,
    output logic          irq,
    input  logic          ext_req,
    output logic          ext_ack,
    output logic          ext_last,
    input  logic          hi_irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err
);
    localparam int SHW = $clog2(DW) + 1;

    dma_state_t    state;
    logic          fly, dir_dst, src_inc, dst_inc, burst, intr, ien;
    logic [1:0]    src_sz, dst_sz, bw;
    logic [CW-1:0] cnt, cnt_after;
    logic [DW-1:0] hold_q;
    logic [2:0]    rd_idx, wr_idx;
    logic          steal_pend, req_q;
    logic [AW-1:0] src_addr, dst_addr;

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
        return ~({DW{1'b1}} << {size_bytes(sz), 3'b000});
    endfunction

    // Element geometry derived from the two port sizes.
    logic [2:0] src_b, dst_b, elem_b, step_b, n_rd, n_wr;
    logic [SHW-1:0] rd_sh, wr_sh;
    always_comb begin
        src_b  = size_bytes(src_sz);
        dst_b  = size_bytes(dst_sz);
        elem_b = (src_b > dst_b) ? src_b : dst_b;
        n_rd   = elem_b >> size_log(src_sz);
        n_wr   = elem_b >> size_log(dst_sz);
        step_b = fly ? src_b : dst_b;
        rd_sh  = SHW'({rd_idx, 3'b000}) << size_log(src_sz);
        wr_sh  = SHW'({wr_idx, 3'b000}) << size_log(dst_sz);
    end

    logic last_rd, last_wr, ok_ack, elem_end, final_x, trig, keep, may_go;
    logic start_cmd, elem_start, cfg_idle, pace_gap, pace_hold;

    // Transfer progress, trigger and continuation decisions.
    always_comb begin
        last_rd    = (rd_idx == n_rd - 3'd1);
        last_wr    = (wr_idx == n_wr - 3'd1);
        ok_ack     = bus_ack && !bus_err;
        cnt_after  = cnt - CW'(step_b);
        elem_end   = ok_ack && ((state == ST_WR && last_wr) || state == ST_FLY);
        final_x    = elem_end && (cnt_after == '0);
        trig       = intr ? 1'b1 : (burst ? ext_req : steal_pend);
        keep       = trig && !hi_irq && !(intr && pace_gap);
        may_go     = trig && !hi_irq && !(intr && pace_hold);
        cfg_idle   = cfg_we && (state == ST_IDLE);
        start_cmd  = cfg_idle && (cfg_sel == 2'(SEL_CTRL)) && cfg_wdata[CB_START];
        elem_start = (state == ST_REQ && bus_gnt) || (elem_end && !final_x && keep);
    end

    dma_addr_gen #(.AW(AW)) u_src (
        .clk(clk), .rst_n(rst_n),
        .load(cfg_idle && cfg_sel == 2'(SEL_SRC)), .load_val(AW'(cfg_wdata)),
        .step(ok_ack && (state == ST_RD || (state == ST_FLY && !dir_dst))),
        .inc_en(src_inc), .step_bytes(src_b), .addr(src_addr)
    );

    dma_addr_gen #(.AW(AW)) u_dst (
        .clk(clk), .rst_n(rst_n),
        .load(cfg_idle && cfg_sel == 2'(SEL_DST)), .load_val(AW'(cfg_wdata)),
        .step(ok_ack && (state == ST_WR || (state == ST_FLY && dir_dst))),
        .inc_en(dst_inc), .step_bytes(step_b), .addr(dst_addr)
    );

    dma_pace u_pace (
        .clk(clk), .rst_n(rst_n), .clear(start_cmd), .bw(bw),
        .elem_done(elem_end), .gap_next(pace_gap), .hold(pace_hold)
    );

    // Bus and handshake outputs decoded from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        bus_valid = (state == ST_RD) || (state == ST_WR) || (state == ST_FLY);
        bus_req   = bus_valid || (state == ST_REQ);
        bus_we    = (state == ST_WR) || (state == ST_FLY && dir_dst);
        bus_addr  = (state == ST_WR || (state == ST_FLY && dir_dst)) ? dst_addr : src_addr;
        bus_size  = (state == ST_WR) ? dst_sz : src_sz;
        bus_wdata = (state == ST_WR) ? ((hold_q >> wr_sh) & lane_mask(dst_sz)) : '0;
        ext_ack   = bus_valid && !intr;
        ext_last  = bus_valid && (cnt == CW'(step_b)) &&
                    ((state == ST_WR && last_wr) || state == ST_FLY);
        irq       = ien && (done_flag || err_flag);
    end

    // Main sequencer: configuration, arming, bus cycles and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            {fly, dir_dst, src_inc, dst_inc, burst, intr, ien} <= '0;
            {src_sz, dst_sz, bw} <= '0;
            cnt <= '0; hold_q <= '0; rd_idx <= '0; wr_idx <= '0;
            done_flag <= 1'b0; err_flag <= 1'b0;
            steal_pend <= 1'b0; req_q <= 1'b0;
        end else begin
            req_q <= ext_req;
            if (ext_req && !req_q) steal_pend <= 1'b1;
            else if (elem_start)   steal_pend <= 1'b0;
            case (state)
                ST_IDLE: if (cfg_we) begin
                    if (cfg_sel == 2'(SEL_COUNT)) cnt <= CW'(cfg_wdata);
                    if (cfg_sel == 2'(SEL_CTRL)) begin
                        fly     <= cfg_wdata[CB_FLY];
                        dir_dst <= cfg_wdata[CB_DIRD];
                        src_inc <= cfg_wdata[CB_SINC];
                        dst_inc <= cfg_wdata[CB_DINC];
                        src_sz  <= cfg_wdata[CB_SSZ +: 2];
                        dst_sz  <= cfg_wdata[CB_DSZ +: 2];
                        burst   <= cfg_wdata[CB_BURST];
                        intr    <= cfg_wdata[CB_INTR];
                        bw      <= cfg_wdata[CB_BW +: 2];
                        ien     <= cfg_wdata[CB_IEN];
                        if (cfg_wdata[CB_START]) begin
                            done_flag  <= 1'b0;
                            err_flag   <= 1'b0;
                            steal_pend <= 1'b0;
                            if (cfg_wdata[CB_FLY] && cfg_wdata[CB_INTR]) err_flag <= 1'b1;
                            else if (cnt == '0) done_flag <= 1'b1;
                            else state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: if (may_go) state <= ST_REQ;
                ST_REQ: if (bus_gnt) begin
                    state  <= fly ? ST_FLY : ST_RD;
                    hold_q <= '0; rd_idx <= '0; wr_idx <= '0;
                end
                ST_RD: if (bus_err) begin
                    state <= ST_IDLE; err_flag <= 1'b1;
                end else if (bus_ack) begin
                    hold_q <= hold_q | ((bus_rdata & lane_mask(src_sz)) << rd_sh);
                    rd_idx <= rd_idx + 3'd1;
                    if (last_rd) state <= ST_WR;
                end
                ST_WR: if (bus_err) begin
                    state <= ST_IDLE; err_flag <= 1'b1;
                end else if (bus_ack) begin
                    cnt    <= cnt_after;
                    wr_idx <= wr_idx + 3'd1;
                    if (last_wr) begin
                        hold_q <= '0; rd_idx <= '0; wr_idx <= '0;
                        if (final_x) begin
                            state <= ST_IDLE; done_flag <= 1'b1;
                        end else state <= keep ? ST_RD : ST_WAIT;
                    end
                end
                ST_FLY: if (bus_err) begin
                    state <= ST_IDLE; err_flag <= 1'b1;
                end else if (bus_ack) begin
                    cnt <= cnt_after;
                    if (final_x) begin
                        state <= ST_IDLE; done_flag <= 1'b1;
                    end else if (!keep) state <= ST_WAIT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_grant_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(bus_gnt));
    p_irq_yield_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_end && hi_irq) |=> !bus_req);
    p_fly_intr_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && cfg_wdata[CB_FLY] && cfg_wdata[CB_INTR]) |=> (err_flag && !busy));
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cnt <= $past(cnt)));
    p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        final_x |=> (done_flag && !busy && !bus_req));
    p_err_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_err) |=> (err_flag && !busy));
endmodule

// File: tb/dma_chan_tb_top.sv
// Bench for dma_chan: a table of copy jobs walked by one loop, then directed tests.
module dma_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        busy, done_flag, err_flag, irq;
    logic        ext_req = 1'b0, ext_ack, ext_last, hi_irq = 1'b0;
    logic        bus_req, bus_gnt, bus_valid, bus_we, bus_ack, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        gnt_en = 1'b1, err_inj = 1'b0;

    logic [7:0]  mem [256];
    int n_rd, n_wr, n_last, n_ack, n_rise;
    logic [31:0] last_addr, first_addr;
    logic        req_prev;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    dma_chan dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .done_flag(done_flag), .err_flag(err_flag), .irq(irq),
        .ext_req(ext_req), .ext_ack(ext_ack), .ext_last(ext_last), .hi_irq(hi_irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    // Bus slave model: zero-wait memory with grant and error injection.
    assign bus_gnt = bus_req && gnt_en;
    assign bus_ack = bus_valid;
    assign bus_err = bus_valid && err_inj;
    always_comb begin
        bus_rdata = {mem[8'(bus_addr + 3)], mem[8'(bus_addr + 2)],
                     mem[8'(bus_addr + 1)], mem[8'(bus_addr)]};
        if (bus_size == 2'd0) bus_rdata[31:8] = '0;
        else if (bus_size == 2'd1) bus_rdata[31:16] = '0;
    end

    always @(posedge clk) begin
        req_prev <= bus_req;
        if (bus_req && !req_prev) n_rise <= n_rise + 1;
        if (bus_valid && bus_ack) begin
            if (n_rd + n_wr == 0) first_addr <= bus_addr;
            last_addr <= bus_addr;
            if (bus_we) n_wr <= n_wr + 1; else n_rd <= n_rd + 1;
            if (ext_last) n_last <= n_last + 1;
            if (ext_ack) n_ack <= n_ack + 1;
            if (bus_we && !bus_err) begin
                mem[8'(bus_addr)] <= bus_wdata[7:0];
                if (bus_size != 2'd0) mem[8'(bus_addr + 1)] <= bus_wdata[15:8];
                if (bus_size != 2'd0 && bus_size != 2'd1) begin
                    mem[8'(bus_addr + 2)] <= bus_wdata[23:16];
                    mem[8'(bus_addr + 3)] <= bus_wdata[31:24];
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] mkctl(input bit fl, input bit dd, input bit si, input bit di,
        input int ss, input int ds, input bit bu, input bit it, input int b, input bit ie);
        return 32'(1) | (32'(fl) << 1) | (32'(dd) << 2) | (32'(si) << 3) | (32'(di) << 4) |
               (32'(ss) << 5) | (32'(ds) << 7) | (32'(bu) << 9) | (32'(it) << 10) |
               (32'(b) << 11) | (32'(ie) << 13);
    endfunction

    task automatic launch(input int s, input int d, input int c, input logic [31:0] ctl);
        n_rd = 0; n_wr = 0; n_last = 0; n_ack = 0; n_rise = 0;
        wr_reg(0, 32'(s)); wr_reg(1, 32'(d)); wr_reg(2, 32'(c)); wr_reg(3, ctl);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    function automatic int diff_bytes(input int s, input int d, input int c);
        int n = 0;
        for (int i = 0; i < c; i++) if (mem[8'(d + i)] != mem[8'(s + i)]) n++;
        return n;
    endfunction

    // ssz, dsz, src, dst, count
    localparam logic [27:0] VEC [6] = '{
        {2'd2, 2'd2, 8'h00, 8'h80, 8'd16},
        {2'd0, 2'd2, 8'h10, 8'h90, 8'd8},
        {2'd2, 2'd0, 8'h20, 8'hA0, 8'd8},
        {2'd1, 2'd0, 8'h30, 8'hB0, 8'd6},
        {2'd0, 2'd1, 8'h40, 8'hC0, 8'd6},
        {2'd1, 2'd2, 8'h50, 8'hD0, 8'd8}
    };

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 flags", int'({done_flag, err_flag, irq, bus_valid}), 0);

        // R3 R4 table of two-cycle copies with mixed port sizes
        for (int v = 0; v < 6; v++) begin
            int ss = int'(VEC[v][27:26]);
            int ds = int'(VEC[v][25:24]);
            int s = int'(VEC[v][23:16]);
            int d = int'(VEC[v][15:8]);
            int c = int'(VEC[v][7:0]);
            launch(s, d, c, mkctl(0, 0, 1, 1, ss, ds, 0, 1, 3, 0));
            wait_idle();
            chk("R3 data", diff_bytes(s, d, c), 0);
            chk("R4 reads", n_rd, c / (1 << ss));
            chk("R4 writes", n_wr, c / (1 << ds));
            chk("R7 last", n_last, 1);
            chk("R7 done", int'(done_flag), 1);
        end

        // R7 zero count: done, no cycles
        launch(0, 8'hF0, 0, mkctl(0, 0, 1, 1, 0, 0, 0, 1, 3, 1));
        repeat (3) @(negedge clk);
        chk("R7 zero done", int'(done_flag), 1);
        chk("R7 zero cycles", n_rd + n_wr, 0);
        chk("R7 irq", int'(irq), 1);

        // R5 flyby read side, burst with request held
        ext_req = 1'b1;
        launch(8'h04, 8'hF0, 8, mkctl(1, 0, 1, 0, 2, 0, 1, 0, 3, 0));
        wait_idle();
        ext_req = 1'b0;
        chk("R5 fly reads", n_rd, 2);
        chk("R5 fly ack", n_ack, 2);
        chk("R5 fly addr", int'(last_addr), 8);
        chk("R7 fly last", n_last, 1);
        chk("R8 burst done", int'(done_flag), 1);

        // R5 R3 flyby write side, fixed destination address
        ext_req = 1'b1;
        launch(0, 8'hF0, 4, mkctl(1, 1, 0, 0, 0, 0, 1, 0, 3, 0));
        wait_idle();
        ext_req = 1'b0;
        chk("R5 fly writes", n_wr, 4);
        chk("R3 fixed addr", int'(last_addr), 32'hF0);
        chk("R3 fixed first", int'(first_addr), 32'hF0);

        // R6 flyby with internal trigger
        launch(0, 8'hF0, 4, mkctl(1, 0, 1, 0, 0, 0, 0, 1, 3, 0));
        repeat (5) @(negedge clk);
        chk("R6 err", int'(err_flag), 1);
        chk("R6 no cycles", n_rd + n_wr, 0);
        chk("R6 idle", int'(busy), 0);

        // R8 cycle steal: one element per rising edge
        launch(8'h60, 8'hE0, 3, mkctl(0, 0, 1, 1, 0, 0, 0, 0, 3, 0));
        repeat (10) @(negedge clk);
        chk("R8 no req", n_wr, 0);
        for (int p = 1; p <= 3; p++) begin
            ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
            repeat (15) @(negedge clk);
            chk("R8 steal", n_wr, p);
        end
        chk("R8 steal done", int'(done_flag), 1);
        chk("R8 steal data", diff_bytes(8'h60, 8'hE0, 3), 0);

        // R9 bandwidth codes: bus request rises per 4-element block
        launch(0, 8'hF8, 4, mkctl(0, 0, 1, 1, 0, 0, 0, 1, 0, 0));
        wait_idle();
        chk("R9 bw0 rises", n_rise, 4);
        launch(0, 8'hF8, 4, mkctl(0, 0, 1, 1, 0, 0, 0, 1, 1, 0));
        wait_idle();
        chk("R9 bw1 rises", n_rise, 2);
        launch(0, 8'hF8, 4, mkctl(0, 0, 1, 1, 0, 0, 0, 1, 3, 0));
        wait_idle();
        chk("R9 bw3 rises", n_rise, 1);

        // R10 pending interrupt keeps the channel off the bus
        hi_irq = 1'b1;
        launch(0, 8'hF8, 4, mkctl(0, 0, 1, 1, 0, 0, 0, 1, 3, 0));
        repeat (20) @(negedge clk);
        chk("R10 held busy", int'(busy), 1);
        chk("R10 no req", int'(bus_req), 0);
        hi_irq = 1'b0;
        wait_idle();
        chk("R10 resumed", int'(done_flag), 1);

        // R12 R2 grant withheld; source write while busy is ignored
        gnt_en = 1'b0;
        launch(0, 8'h70, 4, mkctl(0, 0, 1, 1, 2, 2, 0, 1, 3, 0));
        repeat (20) @(negedge clk);
        chk("R12 req held", int'(bus_req), 1);
        chk("R12 no cycle", int'(bus_valid), 0);
        wr_reg(0, 32'h40);
        gnt_en = 1'b1;
        wait_idle();
        chk("R2 ignored write", diff_bytes(0, 8'h70, 4), 0);

        // R11 bus error stops the channel
        err_inj = 1'b1;
        launch(0, 8'hF8, 4, mkctl(0, 0, 1, 1, 0, 0, 0, 1, 3, 1));
        wait_idle();
        err_inj = 1'b0;
        chk("R11 err", int'(err_flag), 1);
        chk("R11 no done", int'(done_flag), 0);
        chk("R11 irq", int'(irq), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule